// File: doc/BRIEF.md
# Audio Clock Regeneration Packet Scheduler

This block paces the audio clock regeneration packets of a digital video link and supplies the CTS figure that goes into them. When the transmit mode selects burst operation, each rising edge of the vertical blanking strobe starts a burst. The burst holds one more packet than the programmed count. The packets are separated by a programmed number of idle clock cycles. These gaps stop long unbroken runs of packets inside one data-island band. Each request stays raised until the packet assembler reports that the packet has gone out.

In parallel, the block measures CTS by counting TMDS clock cycles between successive pulses of a reference window. It adds a signed 8-bit trim to that count and clamps the result to the output range. Software would normally program a count of 0x1F (32 packets per blanking period), an interval of 0x63 and a trim of zero. In this block these settings are plain inputs.

Top module: `acr_sched_top`

## Requirements
- R1: After reset `pkt_req` is 0 and `cts_val` is 0.
- R2: A rising edge of `vblank`, sampled while `tx_mode` is 2'b10, raises `pkt_req` on the next clock edge.
- R3: In burst mode (`tx_mode` = 2'b10) each `vblank` rising edge yields exactly `burst_cnt + 1` requests, each completed by `pkt_done`.
- R4: A raised `pkt_req` stays high until `pkt_done` is sampled high.
- R5: After a `pkt_done` that is not the last of the burst, `pkt_req` is low for exactly max(`gap_len`, 1) cycles and then rises again.
- R6: A `vblank` rising edge sampled while `tx_mode` is not 2'b10 starts no burst. `burst_cnt` and `gap_len` then have no effect, and `pkt_req` stays low.
- R7: A `vblank` rising edge during a burst drops the packets not yet sent and restarts the schedule from the settings present at that edge.
- R8: On the clock edge that samples `win_pulse` high, `cts_val` becomes P + trim, where P is the number of cycles since the previous sampled pulse and trim is `cts_trim` read as two's complement.
- R9: The trimmed CTS result saturates: below zero it gives 0, and above 2^CTS_W−1 it gives 2^CTS_W−1.
- R10: `cts_val` holds its value on every edge where `win_pulse` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tmds_clk | input | 1 | TMDS clock; clocks all state and is the counted clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| vblank | input | 1 | Vertical blanking strobe; its rising edge starts a burst |
| win_pulse | input | 1 | Reference window pulse, one cycle per measurement window |
| tx_mode | input | 2 | Transmit mode; 2'b10 selects burst scheduling |
| burst_cnt | input | CNT_W (5) | Packets per burst minus one |
| gap_len | input | GAP_W (8) | Idle cycles between packets in a burst |
| cts_trim | input | TRIM_W (8) | Signed correction added to the measured CTS |
| pkt_done | input | 1 | Packet assembler reports the requested packet sent |
| pkt_req | output | 1 | Packet request, held until `pkt_done` |
| cts_val | output | CTS_W (20) | Trimmed, saturated CTS measurement |

## Verification
Every output comes from one register stage. A `vblank` edge or a `pkt_done` shows on `pkt_req` one edge after it is sampled, and a `win_pulse` shows on `cts_val` one edge after it is sampled. The bench drives inputs and samples outputs on falling edges. Each result is therefore read at the first falling edge after the rising edge that produced it. Gap lengths are counted in falling-edge samples of low `pkt_req` between the handshake and the next rise. The CTS periods are set by counting the clock edges between the two window pulses, so the expected P is known exactly.

// File: rtl/acr_pkg.sv
package acr_pkg;

    localparam logic [1:0] MODE_BURST = 2'b10;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_GAP  = 2'd2
    } burst_st_e;

endpackage

// File: rtl/acr_burst_sched.sv
module acr_burst_sched
    import acr_pkg::*;
#(
    parameter int CNT_W = 5,
    parameter int GAP_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             vblank,
    input  logic [1:0]       tx_mode,
    input  logic [CNT_W-1:0] pkt_cnt,
    input  logic [GAP_W-1:0] gap_len,
    input  logic             pkt_done,
    output logic             pkt_req
);

    localparam int REM_W = CNT_W + 1;

    typedef struct packed {
        burst_st_e        st;
        logic             vb;
        logic [REM_W-1:0] rem;
        logic [GAP_W-1:0] gap;
    } sched_t;

    sched_t s_d, s_q;
    logic   vb_rise;

    always_comb begin
        s_d     = s_q;
        vb_rise = vblank & ~s_q.vb;
        s_d.vb  = vblank;

        case (s_q.st)
            ST_REQ: begin
                if (pkt_done) begin
                    if (s_q.rem <= REM_W'(1)) begin
                        s_d.st  = ST_IDLE;
                        s_d.rem = '0;
                    end else begin
                        s_d.st  = ST_GAP;
                        s_d.rem = s_q.rem - REM_W'(1);
                        s_d.gap = gap_len;
                    end
                end
            end
            ST_GAP: begin
                if (s_q.gap <= GAP_W'(1)) begin
                    s_d.st = ST_REQ;
                end else begin
                    s_d.gap = s_q.gap - GAP_W'(1);
                end
            end
            default: begin
                s_d.st = ST_IDLE;
            end
        endcase

        if (vb_rise) begin
            if (tx_mode == MODE_BURST) begin
                s_d.st  = ST_REQ;
                s_d.rem = REM_W'(pkt_cnt) + REM_W'(1);
            end else begin
                s_d.st  = ST_IDLE;
                s_d.rem = '0;
            end
            s_d.gap = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: ST_IDLE, vb: 1'b0, rem: '0, gap: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign pkt_req = (s_q.st == ST_REQ);

    AST_BURST_START: assert property (@(posedge clk) disable iff (!rst_n)
        vb_rise && (tx_mode == MODE_BURST) |=> pkt_req); // R2

    AST_NO_BURST_OTHER_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        vb_rise && (tx_mode != MODE_BURST) |=> !pkt_req); // R6

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_req && !pkt_done && !vb_rise |=> pkt_req); // R4

    AST_DONE_OPENS_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_req && pkt_done && !vb_rise |=> !pkt_req); // R5

endmodule

// File: rtl/acr_cts_meter.sv
module acr_cts_meter #(
    parameter int W      = 20,
    parameter int TRIM_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              win_pulse,
    input  logic [TRIM_W-1:0] trim,
    output logic [W-1:0]      cts_val
);

    localparam int SW = W + 2;

    typedef struct packed {
        logic [W-1:0] cnt;
        logic [W-1:0] cts;
    } meter_t;

    meter_t          m_d, m_q;
    logic [W-1:0]    meas;
    logic [SW-1:0]   sum;
    logic [SW-1:0]   trim_ext;

    always_comb begin
        m_d      = m_q;
        meas     = (&m_q.cnt) ? m_q.cnt : m_q.cnt + W'(1);
        trim_ext = {{(SW-TRIM_W){trim[TRIM_W-1]}}, trim};
        sum      = {2'b00, meas} + trim_ext;

        if (win_pulse) begin
            m_d.cnt = '0;
            if (sum[SW-1]) begin
                m_d.cts = '0;
            end else if (sum[SW-2:W] != '0) begin
                m_d.cts = '1;
            end else begin
                m_d.cts = sum[W-1:0];
            end
        end else begin
            m_d.cnt = meas;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_q <= '{cnt: '0, cts: '0};
        end else begin
            m_q <= m_d;
        end
    end

    assign cts_val = m_q.cts;

    AST_CTS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !win_pulse |=> $stable(cts_val)); // R10

endmodule

// File: rtl/acr_sched_top.sv
module acr_sched_top #(
    parameter int CTS_W  = 20,
    parameter int CNT_W  = 5,
    parameter int GAP_W  = 8,
    parameter int TRIM_W = 8
) (
    input  logic              tmds_clk,
    input  logic              rst_n,
    input  logic              vblank,
    input  logic              win_pulse,
    input  logic [1:0]        tx_mode,
    input  logic [CNT_W-1:0]  burst_cnt,
    input  logic [GAP_W-1:0]  gap_len,
    input  logic [TRIM_W-1:0] cts_trim,
    input  logic              pkt_done,
    output logic              pkt_req,
    output logic [CTS_W-1:0]  cts_val
);

    acr_burst_sched #(
        .CNT_W (CNT_W),
        .GAP_W (GAP_W)
    ) u_sched (
        .clk      (tmds_clk),
        .rst_n    (rst_n),
        .vblank   (vblank),
        .tx_mode  (tx_mode),
        .pkt_cnt  (burst_cnt),
        .gap_len  (gap_len),
        .pkt_done (pkt_done),
        .pkt_req  (pkt_req)
    );

    acr_cts_meter #(
        .W      (CTS_W),
        .TRIM_W (TRIM_W)
    ) u_meter (
        .clk       (tmds_clk),
        .rst_n     (rst_n),
        .win_pulse (win_pulse),
        .trim      (cts_trim),
        .cts_val   (cts_val)
    );

endmodule

// File: tb/acr_sched_top_tb.sv
`timescale 1ns/1ps
module acr_sched_top_tb;

    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          vblank = 1'b0;
    logic          win_pulse = 1'b0;
    logic [1:0]    tx_mode = 2'b00;
    logic [4:0]    burst_cnt = 5'h1F;
    logic [7:0]    gap_len = 8'h63;
    logic [7:0]    cts_trim = 8'h00;
    logic          pkt_done = 1'b0;
    logic          pkt_req;
    logic [CW-1:0] cts_val;

    int n_checks = 0;
    int n_errors = 0;

    always #2.5 clk = ~clk;

    acr_sched_top #(.CTS_W(CW)) u_dut (
        .tmds_clk  (clk),
        .rst_n     (rst_n),
        .vblank    (vblank),
        .win_pulse (win_pulse),
        .tx_mode   (tx_mode),
        .burst_cnt (burst_cnt),
        .gap_len   (gap_len),
        .cts_trim  (cts_trim),
        .pkt_done  (pkt_done),
        .pkt_req   (pkt_req),
        .cts_val   (cts_val)
    );

    // period, trim, expected result (CW = 8 so clamp limit is 255)
    localparam int NV = 6;
    localparam int V_PER[NV]  = '{40, 60, 100, 30, 250, 200};
    localparam int V_TRIM[NV] = '{0, -5, 20, -128, 10, -128};
    localparam int V_EXP[NV]  = '{40, 55, 120, 0, 255, 72};

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run_burst(input logic [1:0] mode, input int cnt, input int gap,
                             input int dly, input string req);
        int  pk = 0;
        int  low = 0;
        int  hi = 0;
        bit  seen = 0;
        int  limit = (cnt + 1) * (gap + dly + 4) + 20;
        int  expg = (gap < 1) ? 1 : gap;
        int  expn = (mode == 2'b10) ? cnt + 1 : 0;
        @(negedge clk);
        pkt_done = 1'b0;
        vblank   = 1'b0;
        @(negedge clk);
        tx_mode   = mode;
        burst_cnt = 5'(cnt);
        gap_len   = 8'(gap);
        vblank    = 1'b1;
        @(negedge clk);
        check(pkt_req == (mode == 2'b10), (mode == 2'b10) ? "R2 start" : "R6 no start",
              int'(pkt_req), int'(mode == 2'b10));
        for (int c = 0; c < limit; c++) begin
            pkt_done = 1'b0;
            if (pkt_req) begin
                if (seen && hi == 0)
                    check(low == expg, "R5 gap", low, expg);
                hi++;
                low = 0;
                if (hi > dly) begin
                    pkt_done = 1'b1;
                    pk++;
                    hi = 0;
                    seen = 1;
                end
            end else begin
                if (hi != 0) check(0, "R4 hold", hi, dly + 1);
                hi = 0;
                low++;
            end
            @(negedge clk);
        end
        pkt_done = 1'b0;
        check(pk == expn, req, pk, expn);
    endtask

    task automatic measure(input int per, input int trim, input int exp);
        logic [CW-1:0] mid;
        @(negedge clk);
        cts_trim  = 8'(trim);
        win_pulse = 1'b1;
        @(negedge clk);
        win_pulse = 1'b0;
        mid = cts_val;
        repeat (per - 1) @(negedge clk);
        check(cts_val == mid, "R10 hold", int'(cts_val), int'(mid));
        win_pulse = 1'b1;
        @(negedge clk);
        win_pulse = 1'b0;
        check(int'(cts_val) == exp, (exp == 0 || exp == 255) ? "R9 clamp" : "R8 value",
              int'(cts_val), exp);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_errors++;
        n_checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(pkt_req == 1'b0, "R1 req", int'(pkt_req), 0);
        check(cts_val == '0, "R1 cts", int'(cts_val), 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            measure(V_PER[i], V_TRIM[i], V_EXP[i]);
        end

        run_burst(2'b10, 31, 99, 0, "R3 default count");
        run_burst(2'b10, 2, 5, 3, "R3 R4 delayed done");
        run_burst(2'b10, 0, 7, 0, "R3 single packet");
        run_burst(2'b10, 3, 0, 0, "R3 R5 zero gap");
        run_burst(2'b01, 3, 5, 0, "R6 mode 01");
        run_burst(2'b11, 31, 1, 0, "R6 mode 11");

        // R7: interrupt a long burst after two packets
        @(negedge clk);
        vblank = 1'b0;
        @(negedge clk);
        tx_mode = 2'b10; burst_cnt = 5'd31; gap_len = 8'd10; vblank = 1'b1;
        for (int k = 0; k < 2; k++) begin
            while (!pkt_req) @(negedge clk);
            pkt_done = 1'b1;
            @(negedge clk);
            pkt_done = 1'b0;
        end
        run_burst(2'b10, 1, 5, 0, "R7 restart count");

        // R7/R6: a strobe in a non-burst mode drops the rest of a burst
        @(negedge clk);
        vblank = 1'b0;
        @(negedge clk);
        tx_mode = 2'b10; burst_cnt = 5'd20; vblank = 1'b1;
        @(negedge clk);
        pkt_done = 1'b1;
        @(negedge clk);
        pkt_done = 1'b0;
        vblank = 1'b0;
        @(negedge clk);
        tx_mode = 2'b00; vblank = 1'b1;
        begin
            int highs = 0;
            for (int c = 0; c < 60; c++) begin
                @(negedge clk);
                if (pkt_req) highs++;
            end
            check(highs == 0, "R7 drop", highs, 0);
        end

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule